// File: doc/BRIEF.md
# DRAM Pattern-Register Read Controller

This block sits on the device side of a DDR3-style memory and governs the pattern-register mode. It receives decoded commands, the bank address, the three low address bits, a bank-idle status and an asynchronous active-low reset. A mode-register write to register 3 turns the mode on or off and selects a readout function. While the mode is on, reads are served from a fixed pattern source instead of the memory array, and every command other than a read or a mode-disabling write is rejected.

Read data leaves as one burst of 8 beats, each marked by a valid strobe, a fixed number of clock cycles after the read command. Pattern data can be masked so that only the prime lane of each byte carries it, or it can be driven on every DQ. Array data is passed through unmasked. Strobe generation, array timing and refresh are handled elsewhere.

Top module: `mpr_read_ctrl`

## Requirements
- R1: A mode-register command (`cmd`=1) with `ba`=3 and `mr_addr[2]`=1, issued while `banks_idle`=1 and the mode is off, sets `mpr_on` and loads `mr_addr[1:0]` into `mpr_sel` at that clock edge.
- R2: A mode-enabling command to register 3 issued while `banks_idle`=0 pulses `err_mrs` high for one cycle after the edge and leaves `mpr_on` and `mpr_sel` unchanged.
- R3: A mode-register command with `ba`=3 and `mr_addr[2]`=0 clears `mpr_on`, whether or not the banks are idle.
- R4: While the mode is on, a READ (`cmd`=2) or READ with auto-precharge (`cmd`=3) produces a burst with `dq_src_mpr`=1 and never raises `array_rd_en`.
- R5: Readout function 00 gives the bit sequence 0,1,0,1,0,1,0,1 over beats 0 to 7. Functions 01, 10 and 11 give all zeros.
- R6: While the mode is on, WRITE (`cmd`=4), power-down entry (5), self-refresh entry (6), other (7) and any mode-register command except a register-3 disable each pulse `err_illegal` for one cycle and change neither `mpr_on`, `mpr_sel` nor `array_wr_en`. `cmd`=0 means no command and is always legal.
- R7: Reset, which is asynchronous and active low, clears `mpr_on`, `mpr_sel`, all flags and any read in flight, and it does so also while the mode is on.
- R8: While the mode is off, the value of `mr_addr[1:0]` has no effect on data. Reads pulse `array_rd_en` and drive `dq_out` = `array_rdata` during their beats, and WRITE pulses `array_wr_en`.
- R9: With `prime_sel`=1, pattern data is driven only on bits whose index is a multiple of 8 (DQ0, and DQ8 when 16 wide). All other bits are 0.
- R10: With `prime_sel`=0, pattern data is driven on every DQ bit.
- R11: The first beat of a read appears RD_LAT clock edges after the command edge. `dq_valid` then stays high for exactly 8 consecutive cycles.
- R12: The mode state and the selection change only on an accepted register-3 mode-register command. A mode-register command to any other `ba` leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Decoded command: 0 none, 1 mode-register, 2 READ, 3 READ+AP, 4 WRITE, 5 power-down, 6 self-refresh, 7 other |
| ba | input | BA_W | Bank address; selects the mode register |
| mr_addr | input | 3 | Address bits [2:0]: bit 2 is the enable, bits [1:0] the function |
| banks_idle | input | 1 | All banks precharged and precharge time met |
| prime_sel | input | 1 | Static: 1 prime-lane output, 0 all-lane output |
| array_rdata | input | DQ_W | Read data from the memory array |
| dq_out | output | DQ_W | Read data toward the DQ pins |
| dq_valid | output | 1 | High on each of the 8 burst beats |
| dq_src_mpr | output | 1 | Current beat comes from the pattern source |
| array_rd_en | output | 1 | Read forwarded to the array |
| array_wr_en | output | 1 | Write forwarded to the array |
| err_mrs | output | 1 | Enable refused because banks were not idle |
| err_illegal | output | 1 | Command not allowed in pattern mode |
| mpr_on | output | 1 | Pattern mode enabled |
| mpr_sel | output | 2 | Stored readout function |

## Verification
On every cycle, the assertions check the following: array enables never coincide with the mode being on, a refused or illegal command never moves the mode state, reserved functions yield zero data, and prime-lane masking clears the non-prime bits. A cycle-by-cycle model in the bench checks the rest through its scenarios. This covers the read latency and the burst length, the alternating pattern beat by beat, the all-lane output, and the effect of reset in the middle of a mode. It also covers that mode-register writes to other registers, and function bits written while the mode is off, leave the reads unchanged.

// File: rtl/mpr_read_ctrl.sv
module mpr_read_ctrl #(
  parameter int DQ_W   = 16,
  parameter int RD_LAT = 5,
  parameter int BA_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cmd,
  input  logic [BA_W-1:0] ba,
  input  logic [2:0]      mr_addr,
  input  logic            banks_idle,
  input  logic            prime_sel,
  input  logic [DQ_W-1:0] array_rdata,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_valid,
  output logic            dq_src_mpr,
  output logic            array_rd_en,
  output logic            array_wr_en,
  output logic            err_mrs,
  output logic            err_illegal,
  output logic            mpr_on,
  output logic [1:0]      mpr_sel
);

  localparam logic [2:0] C_NOP = 3'd0;
  localparam logic [2:0] C_MRS = 3'd1;
  localparam logic [2:0] C_RD  = 3'd2;
  localparam logic [2:0] C_RDA = 3'd3;
  localparam logic [2:0] C_WR  = 3'd4;
  localparam int         BURST = 8;
  localparam logic [2:0] LAST  = 3'(BURST - 1);

  logic is_rd, to_mr3, mrs_take, mrs_bad, illegal;

  assign is_rd    = (cmd == C_RD) || (cmd == C_RDA);
  assign to_mr3   = (cmd == C_MRS) && (ba == BA_W'(3));
  assign mrs_take = to_mr3 && (mpr_on ? !mr_addr[2] : (!mr_addr[2] || banks_idle));
  assign mrs_bad  = to_mr3 && !mpr_on && mr_addr[2] && !banks_idle;
  assign illegal  = mpr_on && (cmd != C_NOP) && !is_rd && !mrs_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpr_on      <= 1'b0;
      mpr_sel     <= 2'b00;
      err_mrs     <= 1'b0;
      err_illegal <= 1'b0;
      array_rd_en <= 1'b0;
      array_wr_en <= 1'b0;
    end else begin
      if (mrs_take) begin
        mpr_on  <= mr_addr[2];
        mpr_sel <= mr_addr[1:0];
      end
      err_mrs     <= mrs_bad;
      err_illegal <= illegal;
      array_rd_en <= is_rd && !mpr_on;
      array_wr_en <= (cmd == C_WR) && !mpr_on;
    end
  end

  logic [RD_LAT-1:0] pv, pm;
  logic [1:0]        pf [RD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      pm <= '0;
      for (int i = 0; i < RD_LAT; i++) pf[i] <= 2'b00;
    end else begin
      pv[0] <= is_rd;
      pm[0] <= mpr_on;
      pf[0] <= mpr_sel;
      for (int i = 1; i < RD_LAT; i++) begin
        pv[i] <= pv[i-1];
        pm[i] <= pm[i-1];
        pf[i] <= pf[i-1];
      end
    end
  end

  logic       act, bm;
  logic [2:0] beat;
  logic [1:0] bf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      bm   <= 1'b0;
      beat <= 3'd0;
      bf   <= 2'b00;
    end else if (pv[RD_LAT-1]) begin
      act  <= 1'b1;
      bm   <= pm[RD_LAT-1];
      bf   <= pf[RD_LAT-1];
      beat <= 3'd0;
    end else if (act) begin
      if (beat == LAST) act <= 1'b0;
      beat <= beat + 3'd1;
    end
  end

  logic [DQ_W-1:0] pmask, lmask;
  logic            pbit;

  for (genvar g = 0; g < DQ_W; g++) begin : g_lane
    assign pmask[g] = (g % 8) == 0;
  end

  assign lmask      = prime_sel ? pmask : '1;
  assign pbit       = (bf == 2'b00) && beat[0];
  assign dq_valid   = act;
  assign dq_src_mpr = act && bm;
  assign dq_out     = !act ? '0 : (bm ? ({DQ_W{pbit}} & lmask) : array_rdata);

  a_r4_no_array_read: assert property (@(posedge clk) disable iff (!rst_n)
    array_rd_en |-> !mpr_on);

  a_r6_no_array_write: assert property (@(posedge clk) disable iff (!rst_n)
    array_wr_en |-> !mpr_on);

  a_r6_state_held: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal |-> (mpr_on && $stable(mpr_sel)));

  a_r2_refused_enable: assert property (@(posedge clk) disable iff (!rst_n)
    err_mrs |-> (!mpr_on && $stable(mpr_sel)));

  a_r9_prime_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_src_mpr && prime_sel) |-> ((dq_out & ~pmask) == '0));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_src_mpr && bf != 2'b00) |-> (dq_out == '0));

endmodule

// File: tb/mpr_read_ctrl_bench.sv
module mpr_read_ctrl_bench;
  localparam int W = 16;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [2:0] ba = 3'd0;
  logic [2:0] mr_addr = 3'd0;
  logic banks_idle = 1'b1;
  logic prime_sel = 1'b1;
  logic [W-1:0] array_rdata = '0;
  logic [W-1:0] dq_out;
  logic dq_valid, dq_src_mpr, array_rd_en, array_wr_en, err_mrs, err_illegal, mpr_on;
  logic [1:0] mpr_sel;

  int total = 0;
  int fails = 0;
  int drv = 0;

  always #4 clk = ~clk;

  mpr_read_ctrl #(.DQ_W(W), .RD_LAT(LAT), .BA_W(3)) u_mpr_read_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .mr_addr(mr_addr),
    .banks_idle(banks_idle), .prime_sel(prime_sel), .array_rdata(array_rdata),
    .dq_out(dq_out), .dq_valid(dq_valid), .dq_src_mpr(dq_src_mpr),
    .array_rd_en(array_rd_en), .array_wr_en(array_wr_en), .err_mrs(err_mrs),
    .err_illegal(err_illegal), .mpr_on(mpr_on), .mpr_sel(mpr_sel));

  int cyc;
  bit m_on, e_mrs, e_ill, e_rd, e_wr;
  bit [1:0] m_sel;
  bit sv[32];
  bit smp[32];
  bit [1:0] sf[32];
  int sb[32];
  bit c_v, c_m;
  bit [1:0] c_f;
  int c_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_on = 0; m_sel = 0;
      e_mrs = 0; e_ill = 0; e_rd = 0; e_wr = 0;
      c_v = 0; c_m = 0; c_f = 0; c_b = 0;
      for (int i = 0; i < 32; i++) sv[i] = 0;
    end else begin
      bit rd, mr3, take;
      cyc++;
      rd = (cmd == 2 || cmd == 3);
      mr3 = (cmd == 1 && ba == 3);
      if (m_on) take = mr3 && !mr_addr[2];
      else take = mr3 && (!mr_addr[2] || banks_idle);
      e_mrs = mr3 && !m_on && mr_addr[2] && !banks_idle;
      e_ill = m_on && cmd != 0 && !rd && !take;
      e_rd = rd && !m_on;
      e_wr = (cmd == 4) && !m_on;
      if (rd)
        for (int b = 0; b < 8; b++) begin
          sv[(cyc+LAT+b)%32] = 1; smp[(cyc+LAT+b)%32] = m_on;
          sf[(cyc+LAT+b)%32] = m_sel; sb[(cyc+LAT+b)%32] = b;
        end
      if (take) begin m_on = mr_addr[2]; m_sel = mr_addr[1:0]; end
      c_v = sv[cyc%32]; c_m = smp[cyc%32]; c_f = sf[cyc%32]; c_b = sb[cyc%32];
      sv[cyc%32] = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_dq();
    logic [W-1:0] e;
    e = '0;
    if (c_v && !c_m) e = array_rdata;
    else if (c_v)
      for (int i = 0; i < W; i++)
        e[i] = (c_f == 0) && (c_b % 2 == 1) && (!prime_sel || i % 8 == 0);
    return e;
  endfunction

  task automatic check_all();
    string dtag;
    dtag = !c_m ? "R8 array data" : (prime_sel ? "R9 prime lane" : "R10 all lanes");
    chk("R1 mode state", 32'(mpr_on), 32'(m_on));
    chk("R12 selection", 32'(mpr_sel), 32'(m_sel));
    chk("R2 enable refused", 32'(err_mrs), 32'(e_mrs));
    chk("R6 illegal flag", 32'(err_illegal), 32'(e_ill));
    chk("R4 array read", 32'(array_rd_en), 32'(e_rd));
    chk("R8 array write", 32'(array_wr_en), 32'(e_wr));
    chk("R11 valid strobe", 32'(dq_valid), 32'(c_v));
    chk("R4 source", 32'(dq_src_mpr), 32'(c_v && c_m));
    if (c_v && c_m && c_f != 0) dtag = "R5 reserved function";
    chk(dtag, 32'(dq_out), 32'(exp_dq()));
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] b, input logic [2:0] a);
    cmd = c; ba = b; mr_addr = a;
    drv++;
    array_rdata = W'(drv * 32'h2f1 ^ 32'h5a5a);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 3'd0, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check_all();
    chk("R7 reset mode off", 32'(mpr_on), 32'd0);
    rst_n = 1'b1;
    // R8: normal mode, function bits written while off have no effect on data
    step(3'd4, 3'd0, 3'd0); idle(1);
    step(3'd1, 3'd3, 3'b001); idle(1);
    step(3'd2, 3'd1, 3'd0); idle(LAT + 9);
    // R12: mode-register write to another register does not enable
    step(3'd1, 3'd0, 3'b100); idle(1);
    chk("R12 other register ignored", 32'(mpr_on), 32'd0);
    // R2: enable with banks busy
    banks_idle = 1'b0;
    step(3'd1, 3'd3, 3'b100); idle(1);
    chk("R2 still off", 32'(mpr_on), 32'd0);
    banks_idle = 1'b1;
    // R1: enable with function 00, prime lanes
    step(3'd1, 3'd3, 3'b100); idle(1);
    chk("R1 enabled", 32'(mpr_on), 32'd1);
    step(3'd2, 3'd0, 3'd0); idle(LAT + 9);
    step(3'd3, 3'd2, 3'd0); idle(LAT + 9);
    // R6: illegal commands in pattern mode
    step(3'd4, 3'd0, 3'd0);
    step(3'd5, 3'd0, 3'd0);
    step(3'd6, 3'd0, 3'd0);
    step(3'd7, 3'd0, 3'd0);
    step(3'd1, 3'd3, 3'b111);
    step(3'd1, 3'd1, 3'b000); idle(2);
    chk("R6 mode kept", 32'(mpr_on), 32'd1);
    chk("R6 selection kept", 32'(mpr_sel), 32'd0);
    // R3: disable, even with banks busy
    banks_idle = 1'b0;
    step(3'd1, 3'd3, 3'b000); idle(1);
    chk("R3 disabled", 32'(mpr_on), 32'd0);
    banks_idle = 1'b1;
    // R10: all-lane output
    prime_sel = 1'b0;
    step(3'd1, 3'd3, 3'b100); idle(1);
    step(3'd2, 3'd0, 3'd0); idle(LAT + 9);
    // R5: reserved function returns zeros
    step(3'd1, 3'd3, 3'b000);
    step(3'd1, 3'd3, 3'b110); idle(1);
    step(3'd3, 3'd0, 3'd0); idle(LAT + 9);
    // R7: reset while enabled and a read in flight
    step(3'd2, 3'd0, 3'd0); idle(LAT + 2);
    rst_n = 1'b0;
    #1;
    check_all();
    chk("R7 reset in mode", 32'(mpr_on), 32'd0);
    chk("R7 burst dropped", 32'(dq_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(3'd2, 3'd0, 3'd0); idle(LAT + 9);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule